// File: doc/BRIEF.md
# Vector Loop Counter Decrement Unit

This unit works out the new loop counter value for a vectorised branch-conditional operation. For each request it takes the current counter, the vector length before and after any length truncation, an optional per-lane predicate mask, and the per-lane results of the condition test. From these it forms a decrement amount and subtracts it from the counter. Evaluating the conditions and deciding whether to branch are done elsewhere.

When counter mode is off, the counter passes through unchanged. When counter mode is on and skipping is off, the decrement is the whole vector length. When skipping is on, the decrement is the number of lanes that count:
- with a predicate present, the enabled lanes;
- with no predicate and the invert select clear, the lanes that passed the test;
- with no predicate and the invert select set, the lanes that failed the test.

Only lanes below the effective vector length are considered. A request is marked by `in_valid`. The results appear one clock later, together with `out_valid`.

Top module: `ctr_vec_decr`

## Requirements
- R1: With `ctr_mode`=1, `vlset_mode`=0 and `skip_en`=0, `dec_amt` equals `vl_full` and `ctr_out` equals `ctr_in` minus `vl_full`.
- R2: With `ctr_mode`=1 and `vlset_mode`=1, the effective length is `vl_trunc` rather than `vl_full`. With `skip_en`=0, `dec_amt` equals `vl_trunc`.
- R3: With `ctr_mode`=1, `skip_en`=1 and `pred_on`=1, `dec_amt` is the number of set bits of `pred_mask` below the effective length. This holds for either value of `inv_sel`.
- R4: With `ctr_mode`=1, `skip_en`=1, `pred_on`=0 and `inv_sel`=0, `dec_amt` is the number of set bits of `lane_pass` below the effective length.
- R5: With `ctr_mode`=1, `skip_en`=1, `pred_on`=0 and `inv_sel`=1, `dec_amt` is the number of clear bits of `lane_pass` below the effective length.
- R6: With `ctr_mode`=0, `dec_amt` is 0 and `ctr_out` equals `ctr_in`, whatever `skip_en`, `inv_sel` and the masks hold.
- R7: Bit i of `pred_mask` or `lane_pass` counts only when i is less than the effective length. Bits at or above it have no effect, and the decrement never exceeds MAXVL.
- R8: `ctr_out` is computed modulo 2^CTRW. A decrement larger than `ctr_in` wraps around.
- R9: `out_valid` is high exactly in the cycle after each cycle where `in_valid` is high. `dec_amt` and `ctr_out` change only in those cycles and otherwise hold. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| ctr_mode | input | 1 | Counter mode active |
| vlset_mode | input | 1 | Length-truncation mode active; selects `vl_trunc` |
| skip_en | input | 1 | Count selected lanes instead of the full length |
| inv_sel | input | 1 | Without a predicate, count failing lanes instead of passing ones |
| pred_on | input | 1 | A predicate mask is supplied |
| pred_mask | input | MAXVL | Per-lane predicate, bit i for lane i |
| lane_pass | input | MAXVL | Per-lane condition result, 1 = pass |
| vl_full | input | VLW | Vector length before truncation (0..MAXVL) |
| vl_trunc | input | VLW | Vector length after truncation (0..MAXVL) |
| ctr_in | input | CTRW | Current counter |
| out_valid | output | 1 | Results valid |
| dec_amt | output | VLW | Amount subtracted |
| ctr_out | output | CTRW | Updated counter |

## Verification
Suppose a wrong mode selection or a wrong lane mask is held in the output registers. It shows as a wrong `dec_amt` in the very cycle `out_valid` rises. Because `ctr_out` is then `ctr_in` minus that wrong amount, the same fault also shows on the counter in that cycle. A corrupted valid or hold register shows one cycle after the request: either as a missing or extra `out_valid` pulse, or as outputs that drift while no request is present.

// File: rtl/ctr_vec_decr.sv
module ctr_vec_decr #(
  parameter int MAXVL = 64,
  parameter int CTRW  = 64,
  parameter int VLW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             ctr_mode,
  input  logic             vlset_mode,
  input  logic             skip_en,
  input  logic             inv_sel,
  input  logic             pred_on,
  input  logic [MAXVL-1:0] pred_mask,
  input  logic [MAXVL-1:0] lane_pass,
  input  logic [VLW-1:0]   vl_full,
  input  logic [VLW-1:0]   vl_trunc,
  input  logic [CTRW-1:0]  ctr_in,
  output logic             out_valid,
  output logic [VLW-1:0]   dec_amt,
  output logic [CTRW-1:0]  ctr_out
);

  logic [VLW-1:0]   vl_eff;
  logic [MAXVL-1:0] live;
  logic [MAXVL-1:0] sel;
  logic [VLW-1:0]   cnt;
  logic [VLW-1:0]   dec_n;

  assign vl_eff = vlset_mode ? vl_trunc : vl_full;

  always_comb begin
    for (int i = 0; i < MAXVL; i++)
      live[i] = (i < int'(vl_eff));
  end

  assign sel = pred_on ? pred_mask : (inv_sel ? ~lane_pass : lane_pass);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < MAXVL; i++)
      cnt = cnt + VLW'(sel[i] & live[i]);
  end

  assign dec_n = !ctr_mode ? '0 : (skip_en ? cnt : vl_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dec_amt   <= '0;
      ctr_out   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dec_amt <= dec_n;
        ctr_out <= ctr_in - CTRW'(dec_n);
      end
    end
  end

endmodule

// File: rtl/ctr_vec_decr_chk.sv
module ctr_vec_decr_chk #(
  parameter int MAXVL = 64,
  parameter int CTRW  = 64,
  parameter int VLW   = $clog2(MAXVL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             ctr_mode,
  input logic             vlset_mode,
  input logic             skip_en,
  input logic             inv_sel,
  input logic             pred_on,
  input logic [MAXVL-1:0] pred_mask,
  input logic [MAXVL-1:0] lane_pass,
  input logic [VLW-1:0]   vl_full,
  input logic [VLW-1:0]   vl_trunc,
  input logic [CTRW-1:0]  ctr_in,
  input logic             out_valid,
  input logic [VLW-1:0]   dec_amt,
  input logic [CTRW-1:0]  ctr_out
);

  a_r1_full_length: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctr_mode && !vlset_mode && !skip_en |=> dec_amt == $past(vl_full));

  a_r2_trunc_length: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && ctr_mode && vlset_mode && !skip_en |=> dec_amt == $past(vl_trunc));

  a_r6_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !ctr_mode |=> dec_amt == '0 && ctr_out == $past(ctr_in));

  a_r7_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> int'(dec_amt) <= MAXVL);

  a_r8_modular: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ctr_out == $past(ctr_in) - CTRW'(dec_amt));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dec_amt) && $stable(ctr_out));

endmodule

bind ctr_vec_decr ctr_vec_decr_chk #(.MAXVL(MAXVL), .CTRW(CTRW), .VLW(VLW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ctr_mode(ctr_mode),
  .vlset_mode(vlset_mode), .skip_en(skip_en), .inv_sel(inv_sel), .pred_on(pred_on),
  .pred_mask(pred_mask), .lane_pass(lane_pass), .vl_full(vl_full), .vl_trunc(vl_trunc),
  .ctr_in(ctr_in), .out_valid(out_valid), .dec_amt(dec_amt), .ctr_out(ctr_out)
);

// File: tb/ctr_vec_decr_bench.sv
`timescale 1ns/100ps
module ctr_vec_decr_bench;
  localparam int MAXVL = 64;
  localparam int CTRW  = 64;
  localparam int VLW   = $clog2(MAXVL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, ctr_mode = 1'b0, vlset_mode = 1'b0, skip_en = 1'b0;
  logic inv_sel = 1'b0, pred_on = 1'b0;
  logic [MAXVL-1:0] pred_mask = '0, lane_pass = '0;
  logic [VLW-1:0] vl_full = '0, vl_trunc = '0;
  logic [CTRW-1:0] ctr_in = '0;
  logic out_valid;
  logic [VLW-1:0] dec_amt;
  logic [CTRW-1:0] ctr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctr_vec_decr u_ctr_vec_decr (.*);

  task automatic check(input string tag, input logic [CTRW-1:0] got, input logic [CTRW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [MAXVL-1:0] below(input int n);
    if (n >= MAXVL) return '1;
    return (MAXVL'(1) << n) - MAXVL'(1);
  endfunction

  task automatic issue(input bit cm, input bit vm, input bit sk, input bit iv, input bit pr,
                       input logic [MAXVL-1:0] pm, input logic [MAXVL-1:0] lp,
                       input int vf, input int vt, input logic [CTRW-1:0] c);
    @(negedge clk);
    in_valid = 1'b1; ctr_mode = cm; vlset_mode = vm; skip_en = sk; inv_sel = iv;
    pred_on = pr; pred_mask = pm; lane_pass = lp;
    vl_full = VLW'(vf); vl_trunc = VLW'(vt); ctr_in = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input int d, input logic [CTRW-1:0] c);
    check({tag, " out_valid"}, CTRW'(out_valid), 1);
    check({tag, " dec_amt"}, CTRW'(dec_amt), CTRW'(d));
    check({tag, " ctr_out"}, ctr_out, c);
  endtask

  task automatic t_reset();
    check("R9 reset out_valid", CTRW'(out_valid), 0);
    check("R9 reset dec_amt", CTRW'(dec_amt), 0);
    check("R9 reset ctr_out", ctr_out, 0);
  endtask

  task automatic t_full();
    issue(1, 0, 0, 0, 0, '0, '0, 5, 2, 100);
    expect_out("R1 full length", 5, 95);
    issue(1, 0, 0, 1, 1, 64'h1, 64'h0, 7, 1, 1000);
    expect_out("R1 ignores masks when not skipping", 7, 993);
  endtask

  task automatic t_trunc();
    issue(1, 1, 0, 0, 0, '0, '0, 8, 3, 50);
    expect_out("R2 truncated length", 3, 47);
    issue(1, 1, 1, 0, 0, '0, '1, 8, 3, 50);
    expect_out("R2 skip counts within truncated length", 3, 47);
  endtask

  task automatic t_pred();
    issue(1, 0, 1, 0, 1, 64'b101, 64'b000, 3, 0, 10);
    expect_out("R3 predicate sz=0", 2, 8);
    issue(1, 0, 1, 1, 1, 64'b101, 64'b111, 3, 0, 10);
    expect_out("R3 predicate sz=1", 2, 8);
  endtask

  task automatic t_pass_fail();
    issue(1, 0, 1, 0, 0, '0, 64'b1011, 4, 0, 20);
    expect_out("R4 passing lanes", 3, 17);
    issue(1, 0, 1, 1, 0, '0, 64'b1011, 4, 0, 20);
    expect_out("R5 failing lanes", 1, 19);
  endtask

  task automatic t_off();
    issue(0, 1, 1, 1, 1, '1, '1, 9, 4, 64'h1234);
    expect_out("R6 counter mode off", 0, 64'h1234);
  endtask

  task automatic t_lanes();
    logic [MAXVL-1:0] m = 64'hF0F0_0000_FFFF_00FF;
    issue(1, 0, 1, 0, 1, '1, '0, 2, 0, 30);
    expect_out("R7 bits above length ignored", 2, 28);
    issue(1, 0, 1, 0, 0, '0, '1, 0, 0, 30);
    expect_out("R7 zero length", 0, 30);
    issue(1, 0, 1, 0, 1, '1, '0, MAXVL, 0, 200);
    expect_out("R7 full width", MAXVL, 200 - MAXVL);
    issue(1, 0, 1, 0, 0, '0, m, 40, 0, 500);
    expect_out("R7 pattern", $countones(m & below(40)), 500 - $countones(m & below(40)));
  endtask

  task automatic t_wrap();
    issue(1, 0, 0, 0, 0, '0, '0, 5, 0, 1);
    expect_out("R8 wrap", 5, 64'hFFFF_FFFF_FFFF_FFFC);
  endtask

  task automatic t_hold();
    issue(1, 0, 0, 0, 0, '0, '0, 6, 0, 77);
    expect_out("R9 pulse", 6, 71);
    @(negedge clk);
    ctr_in = 64'hDEAD; vl_full = VLW'(9);
    @(negedge clk);
    check("R9 out_valid drops", CTRW'(out_valid), 0);
    check("R9 dec_amt holds", CTRW'(dec_amt), 6);
    check("R9 ctr_out holds", ctr_out, 71);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_full();
    t_trunc();
    t_pred();
    t_pass_fail();
    t_off();
    t_lanes();
    t_wrap();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule